// File: doc/BRIEF.md
# Pretrigger Event Capture Buffer

The block keeps a running history of converter samples in a circular memory written on the sample clock. When the trigger input is seen high while the block is armed, it marks an event window. The window holds a programmable number of samples from before the trigger, then the trigger sample, then enough later samples to fill the selected event length. Once the window is complete, writing stops and the stored event is frozen.

The frozen event is then streamed out on a separate, slower read clock. The words come out oldest first, with a valid strobe that stays high for the whole event and never drops in the middle. The two clock domains exchange only two toggle signals: "capture complete" and "readout complete". Writing resumes only after the readout-complete toggle has come back. Any trigger seen while an event is being completed or read out is dropped.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, `out_valid` is 0 and stays 0 until an accepted trigger has completed an event.
- R2: The event length comes from `cfg_size`. Code k in 0..6 selects 2^(k+4) samples (16 up to 1024). Code 7 also selects 1024.
- R3: An event starts P samples before the trigger sample, where P is the effective presample count, so the trigger sample is word P of the event (word 0 is the first). P = 0 makes the trigger sample the first word.
- R4: The effective presample count is `cfg_pre`, limited to the event length minus one. With a larger setting, the trigger sample becomes the last word of the event.
- R5: A trigger is accepted only when the number of samples written since capture last (re)started is at least the effective presample count. A trigger seen before that point is ignored.
- R6: A trigger arriving while post-trigger samples are still being stored, or while an event is being read out, produces no event.
- R7: Read words come out in sample order: each word is the sample taken one sample clock after the previous word.
- R8: For each event, `out_valid` is high on exactly as many consecutive read-clock cycles as the event length, with no gaps.
- R9: After a readout completes, capture restarts, and a trigger held high is accepted again. The new event contains only samples taken after the previous event's last sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Sample clock |
| wr_rst | input | 1 | Synchronous active-high reset, sample domain |
| in_data | input | DATA_W | Sample word |
| in_trig | input | 1 | Trigger level, sampled on `wr_clk` |
| cfg_pre | input | PRE_W | Requested presample count |
| cfg_size | input | CODE_W | Event length code |
| rd_clk | input | 1 | Readout clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_data | output | DATA_W | Event word |
| out_valid | output | 1 | High on every event word |

## Verification
Two functions can land on the same sample-clock edge: the return of the readout-complete toggle, which re-arms capture, and a trigger that has been held high. The bench holds the trigger high with zero presamples across a full readout, so the first re-armed edge also accepts the new trigger. It judges the result by requiring that the second event has full length with no gaps, that its words are consecutive samples, and that its first word comes strictly after the last word of the previous event.

// File: rtl/evcap_pkg.sv
`timescale 1ns/1ps
package evcap_pkg;

  typedef enum logic [1:0] {WS_FILL, WS_POST, WS_HOLD} wr_state_t;
  typedef enum logic {RS_IDLE, RS_READ} rd_state_t;

  // Power-of-two window length; codes past the memory size saturate.
  function automatic int unsigned event_len(input int unsigned code,
                                            input int unsigned min_log,
                                            input int unsigned max_log);
    int unsigned lg;
    lg = min_log + code;
    if (lg > max_log) lg = max_log;
    return 32'd1 << lg;
  endfunction

endpackage

// File: rtl/evcap_ram.sv
`timescale 1ns/1ps
module evcap_ram #(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port, no reset on the data path.
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge rclk) begin
    if (rrst) rvalid <= 1'b0;
    else      rvalid <= re;
  end
endmodule

// File: rtl/evcap_tsync.sv
`timescale 1ns/1ps
module evcap_tsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], tgl_in};
  end

  assign pulse = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/evcap_wr_ctrl.sv
`timescale 1ns/1ps
module evcap_wr_ctrl
  import evcap_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int PRE_W   = 10,
  parameter int CODE_W  = 3,
  parameter int MIN_LOG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [PRE_W-1:0]  pre_cfg,
  input  logic [CODE_W-1:0] size_cfg,
  input  logic              done_pulse,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              take,
  output logic [ADDR_W-1:0] ev_start,
  output logic [ADDR_W:0]   ev_len,
  output logic [ADDR_W:0]   ev_pre,
  output logic              cap_tgl
);
  localparam int LW    = ADDR_W + 1;
  localparam int PW    = (PRE_W > LW) ? PRE_W : LW;
  localparam int DEPTH = 1 << ADDR_W;

  wr_state_t         state;
  logic [ADDR_W-1:0] wptr;
  logic [LW-1:0]     fill;
  logic [LW-1:0]     post_cnt;
  logic [LW-1:0]     len_c;
  logic [LW-1:0]     pre_eff;
  logic [LW-1:0]     post_left;
  logic [PW-1:0]     pre_x;
  logic [PW-1:0]     len_x;

  always_comb begin
    len_c     = LW'(event_len(int'(size_cfg), MIN_LOG, ADDR_W));
    pre_x     = PW'(pre_cfg);
    len_x     = PW'(len_c);
    pre_eff   = (pre_x >= len_x) ? (len_c - 1'b1) : LW'(pre_cfg);
    post_left = len_c - pre_eff - 1'b1;
    take      = (state == WS_FILL) && trig && (fill >= pre_eff);
  end

  assign wr_en   = (state != WS_HOLD);
  assign wr_addr = wptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WS_FILL;
      wptr     <= '0;
      fill     <= '0;
      post_cnt <= '0;
      ev_start <= '0;
      ev_len   <= '0;
      ev_pre   <= '0;
      cap_tgl  <= 1'b0;
    end else begin
      case (state)
        WS_FILL: begin
          wptr <= wptr + 1'b1;
          if (fill != LW'(DEPTH)) fill <= fill + 1'b1;
          if (take) begin
            ev_start <= wptr - ADDR_W'(pre_eff);
            ev_len   <= len_c;
            ev_pre   <= pre_eff;
            post_cnt <= post_left;
            if (post_left == '0) begin
              state   <= WS_HOLD;
              cap_tgl <= ~cap_tgl;
            end else begin
              state <= WS_POST;
            end
          end
        end
        WS_POST: begin
          wptr     <= wptr + 1'b1;
          post_cnt <= post_cnt - 1'b1;
          if (post_cnt == LW'(1)) begin
            state   <= WS_HOLD;
            cap_tgl <= ~cap_tgl;
          end
        end
        WS_HOLD: begin
          if (done_pulse) begin
            state <= WS_FILL;
            fill  <= '0;
          end
        end
        default: state <= WS_FILL;
      endcase
    end
  end
endmodule

// File: rtl/evcap_rd_ctrl.sv
`timescale 1ns/1ps
module evcap_rd_ctrl
  import evcap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pulse,
  input  logic [ADDR_W-1:0] ev_start,
  input  logic [ADDR_W:0]   ev_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   rd_len,
  output logic              done_tgl
);
  rd_state_t       state;
  logic [ADDR_W:0] rem;

  assign rd_en = (state == RS_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      rd_addr  <= '0;
      rem      <= '0;
      rd_len   <= '0;
      done_tgl <= 1'b0;
    end else begin
      case (state)
        RS_IDLE: begin
          if (cap_pulse) begin
            rd_addr <= ev_start;
            rem     <= ev_len;
            rd_len  <= ev_len;
            state   <= RS_READ;
          end
        end
        RS_READ: begin
          rd_addr <= rd_addr + 1'b1;
          rem     <= rem - 1'b1;
          if (rem == (ADDR_W+1)'(1)) begin
            state    <= RS_IDLE;
            done_tgl <= ~done_tgl;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pretrig_capture.sv
`timescale 1ns/1ps
module pretrig_capture #(
  parameter int DATA_W      = 14,
  parameter int ADDR_W      = 10,
  parameter int PRE_W       = 10,
  parameter int CODE_W      = 3,
  parameter int MIN_LOG     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_trig,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic              wr_en;
  logic              take;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] ev_start;
  logic [ADDR_W:0]   ev_len;
  logic [ADDR_W:0]   ev_pre;
  logic              cap_tgl;
  logic              done_tgl;
  logic              cap_pulse;
  logic              done_pulse;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W:0]   rd_len;

  evcap_wr_ctrl #(
    .ADDR_W (ADDR_W),
    .PRE_W  (PRE_W),
    .CODE_W (CODE_W),
    .MIN_LOG(MIN_LOG)
  ) u_wr (
    .clk       (wr_clk),
    .rst       (wr_rst),
    .trig      (in_trig),
    .pre_cfg   (cfg_pre),
    .size_cfg  (cfg_size),
    .done_pulse(done_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .take      (take),
    .ev_start  (ev_start),
    .ev_len    (ev_len),
    .ev_pre    (ev_pre),
    .cap_tgl   (cap_tgl)
  );

  evcap_tsync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk   (rd_clk),
    .rst   (rd_rst),
    .tgl_in(cap_tgl),
    .pulse (cap_pulse)
  );

  evcap_tsync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (wr_clk),
    .rst   (wr_rst),
    .tgl_in(done_tgl),
    .pulse (done_pulse)
  );

  evcap_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .cap_pulse(cap_pulse),
    .ev_start (ev_start),
    .ev_len   (ev_len),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_len   (rd_len),
    .done_tgl (done_tgl)
  );

  evcap_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk  (wr_clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (in_data),
    .rclk  (rd_clk),
    .rrst  (rd_rst),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (out_data),
    .rvalid(out_valid)
  );
endmodule

// File: rtl/pretrig_capture_chk.sv
`timescale 1ns/1ps
module pretrig_capture_chk #(
  parameter int ADDR_W = 10
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              wr_en,
  input logic              take,
  input logic [ADDR_W:0]   ev_pre,
  input logic [ADDR_W:0]   ev_len,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W:0]   rd_len,
  input logic              out_valid
);
  logic [ADDR_W+1:0] fill_seen;
  logic [ADDR_W+1:0] run_cnt;

  always_ff @(posedge wr_clk) begin
    if (wr_rst || !wr_en)    fill_seen <= '0;
    else if (fill_seen != '1) fill_seen <= fill_seen + 1'b1;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst || !out_valid) run_cnt <= '0;
    else                      run_cnt <= run_cnt + 1'b1;
  end

  // R1
  valid_after_reset_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $past(rd_rst) |-> !out_valid);

  // R4
  pre_below_len_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $past(take) |-> (ev_pre < ev_len));

  // R5
  fill_before_take_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $past(take) |-> ($past(fill_seen) >= {1'b0, ev_pre}));

  // R7
  addr_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R8
  run_len_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!out_valid && $past(out_valid)) |-> (run_cnt == {1'b0, rd_len}));

  // R6
  no_overlap_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !(wr_en && rd_en));
endmodule

bind pretrig_capture pretrig_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst   (wr_rst),
  .rd_clk   (rd_clk),
  .rd_rst   (rd_rst),
  .wr_en    (wr_en),
  .take     (take),
  .ev_pre   (ev_pre),
  .ev_len   (ev_len),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_len   (rd_len),
  .out_valid(out_valid)
);

// File: tb/test_pretrig_capture.sv
`timescale 1ns/1ps
module test_pretrig_capture;
  localparam int WR_PERIOD = 4;
  localparam int RD_PERIOD = 10;
  localparam int DW  = 14;
  localparam int PW  = 10;
  localparam int CWD = 3;

  logic           wr_clk = 0;
  logic           rd_clk = 0;
  logic           wr_rst = 1;
  logic           rd_rst = 1;
  logic           in_trig = 0;
  logic [DW-1:0]  in_data = '0;
  logic [PW-1:0]  cfg_pre = '0;
  logic [CWD-1:0] cfg_size = '0;
  logic [DW-1:0]  out_data;
  logic           out_valid;

  pretrig_capture i_pretrig_capture (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_data(in_data), .in_trig(in_trig),
    .cfg_pre(cfg_pre), .cfg_size(cfg_size), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  // Free-running ramp: each sample is the previous one plus one.
  always @(negedge wr_clk) in_data <= in_data + 1'b1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: queue of expected events.
  int          q_base[$];
  int          q_len[$];
  bit          q_free[$];
  string       q_tag[$];
  int          n_expected = 0;
  int          events_seen = 0;
  int          rem = 0;
  logic [DW-1:0] cur = '0;
  logic [DW-1:0] prev_last = '0;
  string       cur_tag = "";

  function automatic int len_of(input int code);
    return (code >= 6) ? 1024 : (16 << code);
  endfunction

  task automatic expect_event(input int base, input int len, input bit free, input string tag);
    q_base.push_back(base & ((1 << DW) - 1));
    q_len.push_back(len);
    q_free.push_back(free);
    q_tag.push_back(tag);
    n_expected++;
  endtask

  // Compare on every read clock, away from the active edge.
  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      if (out_valid) begin
        if (rem == 0) begin
          if (q_len.size() == 0) begin
            chk(1'b0, "R6 unexpected word", int'(out_data), -1);
          end else begin
            rem     = q_len.pop_front();
            cur     = DW'(q_base.pop_front());
            cur_tag = q_tag.pop_front();
            if (q_free.pop_front()) begin
              logic [DW-1:0] gap;
              gap = out_data - prev_last;
              chk(gap >= 1 && gap <= 200, "R9 new event after previous", int'(gap), 1);
              cur = out_data;
            end
          end
        end
        if (rem > 0) begin
          chk(out_data == cur, {cur_tag, " R7 word order"}, int'(out_data), int'(cur));
          cur = cur + 1'b1;
          rem--;
          if (rem == 0) begin
            events_seen++;
            prev_last = out_data;
          end
        end
      end else if (rem > 0) begin
        chk(1'b0, {cur_tag, " R8 valid gap"}, 0, 1);
        rem = 0;
      end
    end
  end

  task automatic fire(input int pre, input int code, input string tag, input bit ok);
    logic [DW-1:0] v;
    int pe;
    @(negedge wr_clk);
    cfg_pre  = PW'(pre);
    cfg_size = CWD'(code);
    @(negedge wr_clk);
    in_trig = 1'b1;
    @(posedge wr_clk);
    #1 v = in_data;
    @(negedge wr_clk);
    in_trig = 1'b0;
    if (ok) begin
      pe = (pre >= len_of(code)) ? len_of(code) - 1 : pre;
      expect_event(int'(v) - pe, len_of(code), 1'b0, tag);
    end
  endtask

  task automatic drain(input int margin);
    while (!(q_len.size() == 0 && rem == 0)) @(negedge rd_clk);
    repeat (10) @(negedge rd_clk);
    repeat (margin) @(negedge wr_clk);
  endtask

  initial begin
    repeat (150000) @(posedge rd_clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    cfg_pre  = PW'(20);
    cfg_size = CWD'(2);
    repeat (5) @(negedge rd_clk);
    rd_rst = 1'b0;
    @(negedge wr_clk);
    wr_rst = 1'b0;

    // R5: too few samples stored yet, pulse must be ignored.
    fire(20, 2, "R5", 1'b0);
    // R1: nothing comes out without an accepted trigger.
    for (int i = 0; i < 20; i++) begin
      @(negedge rd_clk);
      chk(out_valid == 1'b0, "R1 valid idle after reset", int'(out_valid), 0);
    end
    // R5 / R3: accepted trigger with 20 presamples, 64 words.
    fire(20, 2, "R5", 1'b1);
    drain(40);

    // R3: no presamples, trigger sample first.
    fire(0, 1, "R3", 1'b1);
    drain(30);
    fire(7, 3, "R3", 1'b1);
    drain(30);

    // R4: request beyond window clamps to length-1.
    fire(100, 0, "R4", 1'b1);
    drain(30);

    // R6: triggers during post-trigger fill and during readout dropped.
    fire(5, 0, "R6", 1'b1);
    repeat (1) @(negedge wr_clk);
    fire(5, 0, "R6", 1'b0);
    repeat (28) @(negedge wr_clk);
    fire(5, 0, "R6", 1'b0);
    drain(100);
    chk(events_seen == n_expected, "R6 event count", events_seen, n_expected);

    // R2: size code sweep including saturating codes.
    for (int c = 4; c < 8; c++) begin
      fire(9, c, "R2", 1'b1);
      drain(30);
    end
    chk(events_seen == n_expected, "R2 event count", events_seen, n_expected);

    // R9: held trigger meets the re-arm after readout.
    @(negedge wr_clk);
    cfg_pre  = '0;
    cfg_size = '0;
    @(negedge wr_clk);
    in_trig = 1'b1;
    @(posedge wr_clk);
    #1 v = in_data;
    expect_event(int'(v), 16, 1'b0, "R9");
    expect_event(0, 16, 1'b1, "R9");
    while (events_seen < n_expected - 1) @(negedge rd_clk);
    repeat (20) @(negedge wr_clk);
    in_trig = 1'b0;
    drain(100);
    chk(events_seen == n_expected, "R9 event count", events_seen, n_expected);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule